// File: doc/BRIEF.md
# Half-Duplex Two-Wire Register Master

This block is the master side of a sensor register port that uses only two pins. One is a clock the master drives, and the other is a single data line that both sides share. A host asks for one single-byte register access at a time, either a read or a write, with a 7-bit register address. The block sends an 8-bit command in which the top bit selects the direction. A write then sends the data byte straight after the command. A read releases the data line, waits a long pause so the slave can fetch the value, and then clocks in eight bits. After every access the block holds off the next one for a fixed quiet gap.

A separate resynchronisation request realigns a slave whose bit counter has slipped. It pulses the clock once with the data line held high, then leaves both lines high long enough for the slave's transaction watchdog to expire. The clock half-period (1, 2, 5 or 10 µs) is picked per access. All delays are counted in microsecond ticks taken from a prescaler on the system clock.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle and no resync is being requested, so the host may hold `req_valid` with stable fields for as long as needed. The result has no back-pressure: `rsp_done` pulses for one cycle and `rsp_data` holds the last read byte until the next read finishes.

Top module: `sreg_master`

## Requirements
- R1: After reset the clock output is high, the data line is driven high with its output enable high, `req_ready` is high, and `busy` and `rsp_done` are low.
- R2: Each access begins with an 8-bit command sent MSB first. Bit 7 is 1 for a write and 0 for a read, and bits 6..0 are the address. While a transfer is in progress the data output changes only at falling clock edges.
- R3: A write sends the data byte MSB first straight after the command, giving 16 rising clock edges, with the output enable high at every one of them.
- R4: Every clock low phase of an access lasts H µs of prescaler ticks plus at most one system clock. H is 1, 2, 5 or 10 for `speed_sel` values 0, 1, 2 and 3, and it is latched when the request is accepted.
- R5: On a read, after the 8th rising edge the clock stays high for at least TURN_US µs before the first data falling edge. The output enable goes low during this pause, and only while the clock is high.
- R6: On a read, the master samples the data input at the end of each of the next 8 clock high phases, MSB first. `rsp_data` holds the byte when `rsp_done` pulses.
- R7: The output enable comes back high in the same cycle that `rsp_done` pulses, and not before.
- R8: `rsp_done` is a single-cycle pulse, given once per access when the last bit has finished.
- R9: After `rsp_done`, `req_ready` stays low and `busy` stays high for at least GAP_US µs, and the clock makes no edge.
- R10: A request is accepted only when `req_valid` and `req_ready` are both high. A request presented while the block is busy is dropped and starts no transfer.
- R11: A resync request taken while idle has priority over a request in the same cycle. It drives the data line high, gives one clock low phase of SYNC_PULSE_US µs and a high phase of the same length, and then keeps both lines high for SYNC_IDLE_US µs before the block goes idle again.
- R12: While idle, the clock is high and the output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_sel | input | 2 | Clock half-period select: 0=1 µs, 1=2 µs, 2=5 µs, 3=10 µs |
| sync_req | input | 1 | Start a resync sequence when idle |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_data | output | 8 | Last byte read |
| rsp_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access, gap or resync in progress |
| sclk_o | output | 1 | Serial clock to the slave |
| sdio_o | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line output enable |
| sdio_i | input | 1 | Data line input value |

## Verification
Accesses are tried with random direction, address, data and speed, plus directed cases. Address 0x7F with data 0x00 and address 0x00 with the slowest clock show whether the direction bit is placed separately from the address bits. Reads answer with an address-dependent byte from a bench slave model, which would expose a reversed or shifted sample order. A request pulsed during the quiet gap shows that busy-time requests are dropped. A resync raised together with a request shows which of the two wins, and it measures the single clock pulse and the long idle.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SH_LO,
    ST_SH_HI,
    ST_TURN,
    ST_RX_LO,
    ST_RX_HI,
    ST_GAP,
    ST_SY_LO,
    ST_SY_HI,
    ST_SY_WAIT
  } sreg_state_t;

  // Clock half-period in microseconds for each speed code.
  function automatic int unsigned half_us(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 5;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/sreg_tick.sv
module sreg_tick #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] PMAX = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre;

  assign tick = (pre == PMAX) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pre <= '0;
    else if (restart || pre == PMAX) pre <= '0;
    else                             pre <= pre + 1'b1;
  end
endmodule

// File: rtl/sreg_timer.sv
module sreg_timer #(
  parameter int TW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] load,
  input  logic          tick,
  output logic          zero
);
  logic [TW-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start)          cnt <= load;
    else if (tick && !zero)  cnt <= cnt - 1'b1;
  end

  // R4: every delay the engine starts is at least one microsecond long
  assert_load_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !zero);
endmodule

// File: rtl/sreg_engine.sv
module sreg_engine
  import sreg_pkg::*;
#(
  parameter int TW            = 21,
  parameter int TURN_US       = 120,
  parameter int GAP_US        = 121,
  parameter int SYNC_PULSE_US = 100,
  parameter int SYNC_IDLE_US  = 1200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [6:0]    req_addr,
  input  logic [7:0]    req_wdata,
  input  logic [1:0]    speed_sel,
  input  logic          sync_req,
  input  logic          tmr_zero,
  output logic          tmr_start,
  output logic [TW-1:0] tmr_load,
  output logic          sclk_o,
  output logic          sdio_o,
  output logic          sdio_oe,
  input  logic          sdio_i,
  output logic [7:0]    rdata,
  output logic          done,
  output logic          busy
);
  localparam int CMD_BITS  = 8;
  localparam int WR_BITS   = 2 * CMD_BITS;
  localparam int BCW       = $clog2(WR_BITS + 1);
  localparam logic [TW-1:0] TURN_LD  = TW'(TURN_US);
  localparam logic [TW-1:0] GAP_LD   = TW'(GAP_US);
  localparam logic [TW-1:0] PULSE_LD = TW'(SYNC_PULSE_US);
  localparam logic [TW-1:0] IDLE_LD  = TW'(SYNC_IDLE_US);

  sreg_state_t state, nstate;
  logic [TW-1:0]         half_q;
  logic                  wr_q;
  logic [WR_BITS-2:0]    rest;
  logic [BCW-1:0]        bits;
  logic [CMD_BITS-2:0]   rsh;
  logic                  take, smp, fin, last, sync_go;

  assign last      = (bits == BCW'(1));
  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE) && !sync_req;
  assign sync_go   = (state == ST_IDLE) && sync_req;

  always_comb begin
    nstate    = state;
    tmr_start = 1'b0;
    tmr_load  = '0;
    take      = 1'b0;
    smp       = 1'b0;
    fin       = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (sync_req) begin
          nstate = ST_SY_LO; tmr_start = 1'b1; tmr_load = PULSE_LD;
        end else if (req_valid) begin
          take = 1'b1; nstate = ST_SH_LO; tmr_start = 1'b1;
          tmr_load = TW'(half_us(speed_sel));
        end
      end
      ST_SH_LO: if (tmr_zero) begin
        nstate = ST_SH_HI; tmr_start = 1'b1; tmr_load = half_q;
      end
      ST_SH_HI: if (tmr_zero) begin
        tmr_start = 1'b1;
        if (!last) begin
          nstate = ST_SH_LO; tmr_load = half_q;
        end else if (wr_q) begin
          nstate = ST_GAP; tmr_load = GAP_LD; fin = 1'b1;
        end else begin
          nstate = ST_TURN; tmr_load = TURN_LD;
        end
      end
      ST_TURN: if (tmr_zero) begin
        nstate = ST_RX_LO; tmr_start = 1'b1; tmr_load = half_q;
      end
      ST_RX_LO: if (tmr_zero) begin
        nstate = ST_RX_HI; tmr_start = 1'b1; tmr_load = half_q;
      end
      ST_RX_HI: if (tmr_zero) begin
        smp = 1'b1; tmr_start = 1'b1;
        if (last) begin
          nstate = ST_GAP; tmr_load = GAP_LD; fin = 1'b1;
        end else begin
          nstate = ST_RX_LO; tmr_load = half_q;
        end
      end
      ST_GAP: if (tmr_zero) nstate = ST_IDLE;
      ST_SY_LO: if (tmr_zero) begin
        nstate = ST_SY_HI; tmr_start = 1'b1; tmr_load = PULSE_LD;
      end
      ST_SY_HI: if (tmr_zero) begin
        nstate = ST_SY_WAIT; tmr_start = 1'b1; tmr_load = IDLE_LD;
      end
      ST_SY_WAIT: if (tmr_zero) nstate = ST_IDLE;
      default: nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sclk_o  <= 1'b1;
      sdio_o  <= 1'b1;
      sdio_oe <= 1'b1;
      done    <= 1'b0;
      rdata   <= '0;
      rest    <= '0;
      bits    <= '0;
      wr_q    <= 1'b0;
      half_q  <= TW'(1);
      rsh     <= '0;
    end else begin
      state   <= nstate;
      done    <= fin;
      sclk_o  <= !(nstate == ST_SH_LO || nstate == ST_RX_LO || nstate == ST_SY_LO);
      sdio_oe <= !(nstate == ST_TURN || nstate == ST_RX_LO || nstate == ST_RX_HI);
      if (sync_go) sdio_o <= 1'b1;
      if (take) begin
        rest   <= {req_addr, req_wdata};
        wr_q   <= req_write;
        half_q <= TW'(half_us(speed_sel));
        bits   <= req_write ? BCW'(WR_BITS) : BCW'(CMD_BITS);
        sdio_o <= req_write;
      end
      if (state == ST_SH_HI && tmr_zero) begin
        rest <= {rest[WR_BITS-3:0], 1'b0};
        if (last) begin
          bits <= BCW'(CMD_BITS);
        end else begin
          bits   <= bits - 1'b1;
          sdio_o <= rest[WR_BITS-2];
        end
      end
      if (smp) begin
        rsh  <= {rsh[CMD_BITS-3:0], sdio_i};
        bits <= bits - 1'b1;
        if (last) rdata <= {rsh, sdio_i};
      end
    end
  end

  // R12: idle lines are clock high and data driven
  assert_idle_lines_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk_o && sdio_oe));

  // R2: data output does not move while the clock stays high inside a transfer
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sclk_o && $past(sclk_o)) |-> $stable(sdio_o));

  // R5: the line is released only while the clock is high
  assert_release_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdio_oe) |-> sclk_o);

  // R7: output enable returns together with completion
  assert_reassert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> done);

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: no acceptance while busy
  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R11: resync holds the data line driven high
  assert_sync_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SY_LO || state == ST_SY_HI || state == ST_SY_WAIT) |-> (sdio_o && sdio_oe));
endmodule

// File: rtl/sreg_master.sv
module sreg_master #(
  parameter int CLK_PER_US    = 125,
  parameter int TURN_US       = 120,
  parameter int GAP_US        = 121,
  parameter int SYNC_PULSE_US = 100,
  parameter int SYNC_IDLE_US  = 1200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed_sel,
  input  logic       sync_req,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [6:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic [7:0] rsp_data,
  output logic       rsp_done,
  output logic       busy,
  output logic       sclk_o,
  output logic       sdio_o,
  output logic       sdio_oe,
  input  logic       sdio_i
);
  localparam int M1   = (TURN_US > GAP_US) ? TURN_US : GAP_US;
  localparam int M2   = (SYNC_PULSE_US > M1) ? SYNC_PULSE_US : M1;
  localparam int M3   = (SYNC_IDLE_US > M2) ? SYNC_IDLE_US : M2;
  localparam int MAXD = (M3 > 10) ? M3 : 10;
  localparam int TW   = $clog2(MAXD + 1);

  logic          tick, tmr_start, tmr_zero;
  logic [TW-1:0] tmr_load;

  sreg_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(tmr_start), .tick(tick)
  );

  sreg_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(tmr_load),
    .tick(tick), .zero(tmr_zero)
  );

  sreg_engine #(
    .TW(TW), .TURN_US(TURN_US), .GAP_US(GAP_US),
    .SYNC_PULSE_US(SYNC_PULSE_US), .SYNC_IDLE_US(SYNC_IDLE_US)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .speed_sel(speed_sel),
    .sync_req(sync_req),
    .tmr_zero(tmr_zero), .tmr_start(tmr_start), .tmr_load(tmr_load),
    .sclk_o(sclk_o), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i),
    .rdata(rsp_data), .done(rsp_done), .busy(busy)
  );
endmodule

// File: tb/sim_sreg_master.sv
`timescale 1ns/1ps
module sim_sreg_master;
  localparam int P     = 2;
  localparam int TURN  = 120;
  localparam int GAP   = 121;
  localparam int PULSE = 100;
  localparam int IDLEW = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] speed_sel = 2'd0;
  logic sync_req = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] rsp_data;
  logic rsp_done, busy, sclk_o, sdio_o, sdio_oe;
  logic sdio_i = 1'b1;

  sreg_master #(
    .CLK_PER_US(P), .TURN_US(TURN), .GAP_US(GAP),
    .SYNC_PULSE_US(PULSE), .SYNC_IDLE_US(IDLEW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .sync_req(sync_req),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_data(rsp_data),
    .rsp_done(rsp_done), .busy(busy), .sclk_o(sclk_o), .sdio_o(sdio_o),
    .sdio_oe(sdio_oe), .sdio_i(sdio_i)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always_ff @(posedge clk) cyc <= cyc + 1;

  // Monitor and slave model state
  bit        in_txn = 0;
  bit        cur_wr = 0;
  bit        oe_bad = 0;
  bit        turn_oe = 1;
  int        nrise = 0;
  int        nfall = 0;
  int        lo_min, lo_max, lo_last, turn_len, last_edge;
  logic [15:0] cap;
  logic [7:0]  resp_byte;

  function automatic logic [7:0] slave_resp(input logic [6:0] a);
    return {a[3:0], a[6:4], ~a[0]} ^ 8'hA5;
  endfunction

  function automatic int half_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 5;
      default: return 10;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Edge monitor and slave, sampled on the inactive clock edge
  initial begin : monitor
    logic prev;
    prev = 1'b1;
    last_edge = 0;
    forever begin
      @(negedge clk);
      if (sclk_o !== prev) begin
        int len;
        len = cyc - last_edge;
        last_edge = cyc;
        if (sclk_o) begin
          lo_last = len;
          if (in_txn) begin
            if (len < lo_min) lo_min = len;
            if (len > lo_max) lo_max = len;
            cap = {cap[14:0], sdio_o};
            if ((nrise < 8 || cur_wr) && !sdio_oe) oe_bad = 1;
            nrise++;
          end
        end else begin
          if (in_txn && !cur_wr && nrise == 8) begin
            turn_len = len;
            turn_oe  = sdio_oe;
          end
          if (in_txn && !cur_wr && nrise >= 8 && nrise < 16)
            sdio_i = resp_byte[15 - nrise];
          nfall++;
        end
        prev = sclk_o;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    report();
    $finish;
  end

  task automatic run_txn(input bit wr, input logic [6:0] a, input logic [7:0] d,
                         input logic [1:0] s, input bit poke_busy);
    int e, g, nf0;
    do @(negedge clk); while (!req_ready);
    nrise = 0; cap = '0; lo_min = 1 << 30; lo_max = 0; turn_len = 0;
    turn_oe = 1; oe_bad = 0; cur_wr = wr; resp_byte = slave_resp(a); in_txn = 1;
    req_write = wr; req_addr = a; req_wdata = d; speed_sel = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    do @(negedge clk); while (!rsp_done);
    in_txn = 0;
    e = half_of(s) * P;
    chk(sdio_oe == 1'b1, "R7 oe at done", sdio_oe, 1);
    chk(nrise == 16, "R3 R6 rising edge count", nrise, 16);
    chk(cap[15:8] == {wr, a}, "R2 command byte", cap[15:8], {wr, a});
    chk(lo_min >= e && lo_max <= e + 1, "R4 low phase length", lo_max, e);
    if (wr) begin
      chk(cap[7:0] == d, "R3 write data byte", cap[7:0], d);
      chk(!oe_bad, "R3 oe during write", oe_bad, 0);
    end else begin
      chk(!oe_bad, "R2 oe during command", oe_bad, 0);
      chk(rsp_data == slave_resp(a), "R6 read data", rsp_data, slave_resp(a));
      chk(turn_len >= TURN * P, "R5 turnaround length", turn_len, TURN * P);
      chk(turn_oe == 1'b0, "R5 released during read", turn_oe, 0);
    end
    nf0 = nfall;
    g = 0;
    @(negedge clk);
    g++;
    chk(rsp_done == 1'b0, "R8 done one cycle", rsp_done, 0);
    if (poke_busy) begin
      req_valid = 1'b1; req_write = ~wr; req_addr = ~a;
      @(negedge clk);
      g++;
      req_valid = 1'b0;
    end
    while (!req_ready) begin
      @(negedge clk);
      g++;
    end
    chk(g >= GAP * P, "R9 quiet gap length", g, GAP * P);
    repeat (3) @(negedge clk);
    chk(nfall == nf0 && !busy, "R10 R9 no transfer in gap", nfall - nf0, 0);
  endtask

  task automatic run_sync;
    int nf0, n;
    bit bad;
    do @(negedge clk); while (!req_ready);
    nf0 = nfall; bad = 0; n = 0;
    sync_req = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 7'h11;
    @(negedge clk);
    sync_req = 1'b0; req_valid = 1'b0;
    while (busy) begin
      if (!(sdio_o && sdio_oe)) bad = 1;
      n++;
      @(negedge clk);
    end
    chk(!bad, "R11 data high during resync", bad, 0);
    chk(nfall - nf0 == 1, "R11 single clock pulse", nfall - nf0, 1);
    chk(lo_last >= PULSE * P && lo_last <= PULSE * P + 1, "R11 pulse length", lo_last, PULSE * P);
    chk(n >= (2 * PULSE + IDLEW) * P && n <= (2 * PULSE + IDLEW) * P + 4,
        "R11 resync duration", n, (2 * PULSE + IDLEW) * P);
    chk(sclk_o && req_ready, "R12 idle after resync", sclk_o, 1);
  endtask

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk_o == 1'b1, "R1 reset clock high", sclk_o, 1);
    chk(sdio_oe == 1'b1 && sdio_o == 1'b1, "R1 reset data driven high", {sdio_oe, sdio_o}, 3);
    chk(req_ready == 1'b1 && !busy && !rsp_done, "R1 reset idle", req_ready, 1);

    run_txn(1'b1, 7'h7F, 8'h00, 2'd0, 1'b0);
    run_txn(1'b0, 7'h00, 8'h00, 2'd3, 1'b0);
    run_txn(1'b1, 7'h2A, 8'hC3, 2'd1, 1'b1);
    run_txn(1'b0, 7'h55, 8'h00, 2'd2, 1'b1);
    run_sync();
    for (int i = 0; i < 24; i++) begin
      run_txn(1'($urandom), 7'($urandom), 8'($urandom), 2'($urandom), 1'($urandom));
    end
    report();
    $finish;
  end
endmodule